// File: doc/BRIEF.md
# Plug-and-Play Initiation Key Detector

This block sits on a narrow byte-wide I/O bus and guards the configuration space of a plug-and-play card. After reset the card is asleep in a wait-for-key state: it only watches the bytes written to its address port. It compares them against a 32-byte sequence that an 8-bit linear feedback shift register produces. When all 32 bytes arrive in order with no stray address write in between, the card moves to the configuration state.

In the configuration state the address port selects a register index and a separate write-data port stores a value into the indexed register. A read port returns the indexed register. Four indices are live: a card-number register, a logical-device selector, an activation flag for the selected device, and a control register whose bit 1 sends the card back to sleep. A fifth index, the isolation index, turns reads of the read port into a serial readout of a 72-bit card identifier. Each identifier bit takes two reads.

Every read of the read port produces a one-cycle response marked by `rd_valid`. The response has no ready input: the consumer takes it in the cycle it appears. Write strobes are one cycle wide and are always accepted.

Top module: `pnp_key_detect`

## Requirements
- R1: After reset the block is in wait-for-key (`cfg_active` = 0) and `rd_valid` is 0; the card number and device selector reset to 0 and every device activation flag resets to 1.
- R2: In wait-for-key, `cfg_active` rises in the cycle after the clock edge that takes the 32nd consecutive matching address-port write (bus_sel = 0), and not before.
- R3: In wait-for-key, an address-port write that does not equal the expected key byte sends the matcher back to the first key byte, so the key has to be sent again from its start.
- R4: The first key byte is 0x6A; each next byte is the current byte shifted right by one, with the new bit 7 equal to bit 0 XOR bit 1 of the current byte (0x6A, 0xB5, 0xDA, ... ending 0x73, 0x39). Two leading 0x00 writes are allowed before the key.
- R5: In wait-for-key, writes to the write-data port (bus_sel = 1) change no register, and reads of the read port return 0x00.
- R6: A read strobe with bus_sel = 2 yields `rd_valid` = 1 with `rd_data` for exactly the next cycle; a read strobe with any other bus_sel yields no response.
- R7: In configuration, an address-port write sets the register index; a write-data write stores into the indexed register; a read returns the indexed register. Index 0x07 is the device selector (read back as written); any index other than 0x01, 0x06, 0x07, 0x30 reads 0x00.
- R8: Writing a value to index 0x06 sets the card number; a later read at index 0x06 returns it.
- R9: Writing a value to index 0x30 sets the selected device's activation flag to bit 0 of the value (0 disables); other devices are unaffected. A read at 0x30 returns the flag in bit 0. A selector value of NUM_DEV or more has no flag: writes are dropped and reads return 0x00.
- R10: At index 0x01 each identifier bit takes two reads: 0x55 then 0xAA for a one, 0x00 then 0x00 for a zero. Bits come out LSB first within each byte, byte 0 first (identifier bit k = ID_VALUE[k]); after bit 71 the readout wraps to bit 0.
- R11: Any address-port write restarts the isolation readout at bit 0, first read of the pair.
- R12: In configuration, a write-data write at index 0x02 with bit 1 set returns the block to wait-for-key, and the key must be sent again from its start; with bit 1 clear it has no effect. The card number and activation flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe, one cycle per write |
| bus_rd | input | 1 | Byte read strobe, one cycle per read |
| bus_sel | input | 2 | Port select: 0 address, 1 write data, 2 read data, 3 unused |
| bus_wdata | input | 8 | Write data byte |
| rd_valid | output | 1 | Read response valid, one cycle after a read-port strobe |
| rd_data | output | 8 | Read response byte |
| cfg_active | output | 1 | 1 in the configuration state, 0 in wait-for-key |

## Verification
A matcher that counts wrongly or keeps its position after a mismatch shows at `cfg_active` in the cycle after the 32nd key write: it rises too early, too late, or after a broken key. A wrong isolation pointer or phase shows up at the next read-port response as a misplaced 0x55 or 0xAA. A wrong register or activation flag shows up at the first read at its index. The sweeps cover a mismatch at every key position, every card number value, every device, and two full passes over the identifier, so each fault appears within one sweep step.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

  // Port select codes on bus_sel
  localparam logic [1:0] PORT_ADDR  = 2'd0;
  localparam logic [1:0] PORT_WDATA = 2'd1;
  localparam logic [1:0] PORT_RDATA = 2'd2;

  // Register indices
  localparam logic [7:0] IDX_ISOL = 8'h01;
  localparam logic [7:0] IDX_CTRL = 8'h02;
  localparam logic [7:0] IDX_CARD = 8'h06;
  localparam logic [7:0] IDX_LDEV = 8'h07;
  localparam logic [7:0] IDX_ACT  = 8'h30;

  // Isolation response bytes
  localparam logic [7:0] ISO_FIRST  = 8'h55;
  localparam logic [7:0] ISO_SECOND = 8'hAA;

  typedef enum logic {ST_WAIT_KEY = 1'b0, ST_CONFIG = 1'b1} card_state_e;

  // Next key byte: shift right, new MSB = bit0 ^ bit1
  function automatic logic [7:0] key_step(input logic [7:0] cur);
    return {cur[0] ^ cur[1], cur[7:1]};
  endfunction

endpackage

// File: rtl/pnp_key_matcher.sv
module pnp_key_matcher
  import pnp_key_pkg::*;
#(
  parameter int         KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       addr_wr,
  input  logic [7:0] wdata,
  output logic       key_done
);
  localparam int CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_LEN - 1);

  logic [7:0]       expect_q;
  logic [CNT_W-1:0] count_q;
  logic             hit;

  assign hit      = arm && addr_wr && (wdata == expect_q);
  assign key_done = hit && (count_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      expect_q <= KEY_SEED;
      count_q  <= '0;
    end else if (addr_wr) begin
      if (hit && !key_done) begin
        expect_q <= key_step(expect_q);
        count_q  <= count_q + 1'b1;
      end else begin
        expect_q <= KEY_SEED;
        count_q  <= '0;
      end
    end
  end

endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_key_pkg::*;
#(
  parameter int NUM_DEV = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  logic       addr_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] idx,
  output logic [7:0] reg_rdata,
  output logic       leave_cfg
);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [7:0]         idx_q;
  logic [7:0]         card_q;
  logic [7:0]         ldev_q;
  logic [NUM_DEV-1:0] act_q;
  logic               dev_ok;
  logic [DEV_W-1:0]   dev_sel;

  assign dev_ok    = (int'(ldev_q) < NUM_DEV);
  assign dev_sel   = ldev_q[DEV_W-1:0];
  assign idx       = idx_q;
  assign leave_cfg = cfg_en && data_wr && (idx_q == IDX_CTRL) && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      card_q <= '0;
      ldev_q <= '0;
      act_q  <= '1;
    end else if (cfg_en) begin
      if (addr_wr) idx_q <= wdata;
      if (data_wr) begin
        case (idx_q)
          IDX_CARD: card_q <= wdata;
          IDX_LDEV: ldev_q <= wdata;
          IDX_ACT:  if (dev_ok) act_q[dev_sel] <= wdata[0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_q)
      IDX_CARD: reg_rdata = card_q;
      IDX_LDEV: reg_rdata = ldev_q;
      IDX_ACT:  reg_rdata = {7'd0, dev_ok && act_q[dev_sel]};
      default:  reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/pnp_isolation.sv
module pnp_isolation
  import pnp_key_pkg::*;
#(
  parameter int                    ID_BITS  = 72,
  parameter logic [ID_BITS-1:0]    ID_VALUE = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       step,
  output logic [7:0] iso_byte
);
  localparam int PTR_W = (ID_BITS > 1) ? $clog2(ID_BITS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ID_BITS - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             second_q;
  logic             cur_bit;

  assign cur_bit  = ID_VALUE[ptr_q];
  assign iso_byte = !cur_bit ? 8'h00 : (second_q ? ISO_SECOND : ISO_FIRST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ptr_q    <= '0;
      second_q <= 1'b0;
    end else if (step) begin
      second_q <= !second_q;
      if (second_q) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/pnp_key_detect.sv
module pnp_key_detect
  import pnp_key_pkg::*;
#(
  parameter int           KEY_LEN  = 32,
  parameter logic [7:0]   KEY_SEED = 8'h6A,
  parameter int           ID_BYTES = 9,
  parameter logic [71:0]  ID_VALUE = 72'hA5_3C_0F_96_E1_7B_00_FF_5A,
  parameter int           NUM_DEV  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       cfg_active
);
  localparam int ID_BITS = ID_BYTES * 8;

  card_state_e state_q;
  logic        in_cfg;
  logic        addr_wr, data_wr, port_rd;
  logic        key_done, leave_cfg;
  logic [7:0]  idx, reg_rdata, iso_byte;
  logic        iso_step;

  assign in_cfg   = (state_q == ST_CONFIG);
  assign addr_wr  = bus_wr && (bus_sel == PORT_ADDR);
  assign data_wr  = bus_wr && (bus_sel == PORT_WDATA);
  assign port_rd  = bus_rd && (bus_sel == PORT_RDATA);
  assign iso_step = in_cfg && port_rd && (idx == IDX_ISOL);

  pnp_key_matcher #(.KEY_LEN(KEY_LEN), .KEY_SEED(KEY_SEED)) u_match (
    .clk(clk), .rst_n(rst_n), .arm(!in_cfg), .addr_wr(addr_wr),
    .wdata(bus_wdata), .key_done(key_done)
  );

  pnp_cfg_regs #(.NUM_DEV(NUM_DEV)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_en(in_cfg), .addr_wr(addr_wr),
    .data_wr(data_wr), .wdata(bus_wdata), .idx(idx),
    .reg_rdata(reg_rdata), .leave_cfg(leave_cfg)
  );

  pnp_isolation #(.ID_BITS(ID_BITS), .ID_VALUE(ID_VALUE[ID_BITS-1:0])) u_iso (
    .clk(clk), .rst_n(rst_n), .restart(addr_wr), .step(iso_step),
    .iso_byte(iso_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_KEY;
    end else begin
      case (state_q)
        ST_WAIT_KEY: if (key_done)  state_q <= ST_CONFIG;
        ST_CONFIG:   if (leave_cfg) state_q <= ST_WAIT_KEY;
        default:     state_q <= ST_WAIT_KEY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= port_rd;
      if (!port_rd || !in_cfg) rd_data <= 8'h00;
      else if (idx == IDX_ISOL) rd_data <= iso_byte;
      else rd_data <= reg_rdata;
    end
  end

  assign cfg_active = in_cfg;

endmodule

// File: rtl/pnp_key_chk.sv
module pnp_key_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_sel,
  input logic [7:0] bus_wdata,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       cfg_active
);
  // R6
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == 2'd2) |=> rd_valid);

  // R6
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_sel == 2'd2) |=> !rd_valid);

  // R5
  wait_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_active && bus_rd && bus_sel == 2'd2) |=> (rd_data == 8'h00));

  // R2
  enter_on_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_active) |-> $past(bus_wr && bus_sel == 2'd0));

  // R12
  leave_on_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_active) |-> $past(bus_wr && bus_sel == 2'd1 && bus_wdata[1]));

  // R10
  iso_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_data == 8'h55) |-> cfg_active);
endmodule

bind pnp_key_detect pnp_key_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_sel(bus_sel), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .cfg_active(cfg_active)
);

// File: tb/tb_pnp_key_detect.sv
module tb_pnp_key_detect;
  localparam logic [71:0] ID = 72'hA5_3C_0F_96_E1_7B_00_FF_5A;
  localparam int NDEV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic rd_valid, cfg_active;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pnp_key_detect #(.ID_VALUE(ID), .NUM_DEV(NDEV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .cfg_active(cfg_active)
  );

  function automatic logic [7:0] key_byte(input int n);
    logic [7:0] v = 8'h6A;
    for (int i = 0; i < n; i++) v = {v[0] ^ v[1], v[7:1]};
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d, output logic v);
    @(negedge clk); bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk); bus_rd = 1'b0; d = rd_data; v = rd_valid;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    logic [7:0] d; logic v;
    rd(2'd2, d, v);
    chk(req, {23'd0, v, d}, {23'd0, 1'b1, exp});
  endtask

  task automatic send_key();
    wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    for (int i = 0; i < 32; i++) wr(2'd0, key_byte(i));
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    wr(2'd0, i); wr(2'd1, v);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cfg_active", {31'd0, cfg_active}, 0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 0);
    // R5 wait state: reads zero, data-port writes ignored
    rd_chk("R5 wait read", 8'h00);
    wr(2'd0, 8'h06); wr(2'd1, 8'h77);
    // R6 read strobe on non-read port gives no response
    rd(2'd0, d, v);
    chk("R6 no response on other port", {31'd0, v}, 0);

    // R3 mismatch at every key position
    for (int p = 0; p < 32; p++) begin
      wr(2'd0, 8'h00); wr(2'd0, 8'h00);
      for (int i = 0; i < p; i++) wr(2'd0, key_byte(i));
      wr(2'd0, key_byte(p) ^ 8'h80);
      for (int i = p + 1; i < 32; i++) wr(2'd0, key_byte(i));
      chk("R3 broken key stays locked", {31'd0, cfg_active}, 0);
    end

    // R2 R4 full key, enters only on the 32nd byte
    wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    for (int i = 0; i < 31; i++) wr(2'd0, key_byte(i));
    chk("R2 not before 32nd byte", {31'd0, cfg_active}, 0);
    chk("R4 last key bytes", {16'd0, key_byte(30), key_byte(31)}, 32'h7339);
    wr(2'd0, key_byte(31));
    chk("R4 R2 unlocked after key", {31'd0, cfg_active}, 1);

    // R5 earlier wait-state data write left card number at reset value
    wr(2'd0, 8'h06);
    rd_chk("R5 card number untouched", 8'h00);
    rd_chk("R1 card number reset", 8'h00);

    // R8 card number sweep
    for (int n = 0; n < 256; n++) begin
      set_reg(8'h06, 8'(n));
      rd_chk("R8 card number", 8'(n));
    end

    // R7 unassigned index and selector readback
    wr(2'd0, 8'h20); rd_chk("R7 unassigned index", 8'h00);
    wr(2'd0, 8'h02); rd_chk("R7 control reads zero", 8'h00);

    // R9 device activation sweep
    for (int dv = 0; dv < NDEV; dv++) begin
      set_reg(8'h07, 8'(dv));
      rd_chk("R7 selector readback", 8'(dv));
      wr(2'd0, 8'h30);
      rd_chk("R9 flag before disable", 8'h01);
      wr(2'd1, 8'h00);
      for (int e = 0; e < NDEV; e++) begin
        set_reg(8'h07, 8'(e));
        wr(2'd0, 8'h30);
        rd_chk("R9 flags after disable", (e <= dv) ? 8'h00 : 8'h01);
      end
    end
    set_reg(8'h07, 8'(NDEV));
    set_reg(8'h30, 8'h01);
    rd_chk("R9 out of range selector", 8'h00);
    set_reg(8'h07, 8'd2);
    set_reg(8'h30, 8'hFF);
    rd_chk("R9 re-enable uses bit 0", 8'h01);

    // R10 isolation readout, two passes to cover wrap
    wr(2'd0, 8'h01);
    for (int k = 0; k < 144; k++) begin
      rd_chk("R10 first read", ID[k % 72] ? 8'h55 : 8'h00);
      rd_chk("R10 second read", ID[k % 72] ? 8'hAA : 8'h00);
    end

    // R11 restart on address write, also mid-pair
    wr(2'd0, 8'h01);
    for (int k = 0; k < 3; k++) begin rd(2'd2, d, v); rd(2'd2, d, v); end
    rd(2'd2, d, v);
    wr(2'd0, 8'h01);
    rd_chk("R11 restart first read", ID[0] ? 8'h55 : 8'h00);
    rd_chk("R11 restart second read", ID[0] ? 8'hAA : 8'h00);
    rd_chk("R11 next bit", ID[1] ? 8'h55 : 8'h00);

    // R12 control register
    set_reg(8'h02, 8'hFD);
    chk("R12 bit1 clear stays", {31'd0, cfg_active}, 1);
    set_reg(8'h02, 8'h02);
    chk("R12 leave config", {31'd0, cfg_active}, 0);
    rd_chk("R5 read after leave", 8'h00);
    for (int i = 1; i < 32; i++) wr(2'd0, key_byte(i));
    chk("R12 key restarts from start", {31'd0, cfg_active}, 0);
    send_key();
    chk("R12 re-enter config", {31'd0, cfg_active}, 1);
    wr(2'd0, 8'h06);
    rd_chk("R12 card number kept", 8'hFF);
    set_reg(8'h07, 8'd0); wr(2'd0, 8'h30);
    rd_chk("R12 flags kept", 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule